// File: doc/BRIEF.md
# Port Pin-Change Interrupt Detector

This block watches the upper half of an 8-bit input port and raises a sticky change flag when any watched pin differs from a reference copy of the pin levels. The reference is not refreshed every clock. It is captured only when software reads or writes the port. A change therefore stays "pending" until the port is accessed, and software cannot clear the flag while the difference persists.

Each watched pin has its own enable bit and takes part only while its direction bit marks it as an input. A global interrupt enable turns the sticky flag into an interrupt request. The wake request is also gated by the global enable and is raised combinationally from the live comparison. A sleep controller can therefore see a change even while the core clock is stopped.

Typical use: the interrupt handler reads the port, which moves the reference to the current levels. It then pulses the clear strobe in a later cycle. If the pins moved again after the read, the flag stays set and the handler runs again.

Top module: `port_chg_detect`

## Requirements
- R1: Only pins 7..4 can set the flag. Bit i of `chgEnable` (1 = enabled) controls pin 4+i. Level changes on pins 3..0, or on a pin whose enable bit is 0, never set the flag. A disabled pin is still compared against the reference that was captured at the last access.
- R2: A pin whose `dirIn` bit is 0 (output) is excluded from the comparison.
- R3: A one-cycle `portRead` or `portWrite` strobe captures the present levels of pins 7..4 into the reference at that clock edge. From the next cycle onward, those levels produce no mismatch.
- R4: When an enabled input pin differs from the reference, `chgFlag` is 1 after the next rising clock edge.
- R5: Once set, `chgFlag` stays 1 until a `flagClear` strobe takes effect. A port access by itself does not clear it.
- R6: A `flagClear` strobe in a cycle that has an active mismatch leaves `chgFlag` at 1, because setting wins over clearing.
- R7: A `flagClear` strobe in a cycle with no mismatch makes `chgFlag` 0 after that clock edge.
- R8: `irqReq` is 1 exactly when `chgFlag` is 1 and `intEnable` is 1. With `intEnable` at 0 the flag still sets, but no request is raised.
- R9: `wakeReq` is 1 without waiting for a clock edge when `intEnable` is 1 and either a mismatch exists or `chgFlag` is 1. It is 0 whenever `intEnable` is 0.
- R10: While `rstN` is 0, the flag is held at 0 and the reference follows the pin levels. After release, pins left unchanged produce no flag, no `irqReq` and no `wakeReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Synchronous active-low reset |
| pinLevel | input | 8 | Synchronized port pin levels |
| dirIn | input | 8 | Per-pin direction, 1 = input |
| chgEnable | input | 4 | Per-pin change enable for pins 7..4 |
| intEnable | input | 1 | Global change-interrupt enable |
| portRead | input | 1 | Port read strobe, captures the reference |
| portWrite | input | 1 | Port write strobe, captures the reference |
| flagClear | input | 1 | Software clear of the change flag |
| chgFlag | output | 1 | Sticky change flag |
| irqReq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Combinational wake request |

## Verification
The bench pulses the clear strobe while a difference is still present. A design in which clearing wins over setting would drop the flag and lose the event. It also clears the flag after a read or a write and checks that the flag stays down. A design that compared the pins against last cycle's levels instead of the access-time copy would behave differently when a disabled pin is later re-enabled. Only the access-time copy makes that pin raise the flag at once. The remaining checks cover the low pins, pins set as outputs and the global gate. For each, a leaky mask or gate would show up as a spurious flag, request or wake. The wake output is sampled before the clock edge, which catches a registered wake path.

// File: rtl/port_chg_pkg.sv
package port_chg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // load the reference from the pins
  } chgCtl_t;

endpackage

// File: rtl/port_chg_datapath.sv
module port_chg_datapath
  import port_chg_pkg::*;
#(
  parameter int CHG_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  chgCtl_t          ctl,
  input  logic [CHG_W-1:0] watchLevel,
  input  logic [CHG_W-1:0] watchDir,
  input  logic [CHG_W-1:0] watchEn,
  output logic             anyMismatch
);

  logic [CHG_W-1:0] refSnap;
  logic [CHG_W-1:0] laneHit;

  // Reference copy, refreshed only on capture strobes
  always_ff @(posedge clk) begin
    if (ctl.capture) refSnap <= watchLevel;
  end

  // One comparison lane per watched pin
  for (genvar g = 0; g < CHG_W; g++) begin : gLane
    always_comb begin
      laneHit[g] = watchEn[g] & watchDir[g] & (watchLevel[g] ^ refSnap[g]);
    end
  end

  assign anyMismatch = |laneHit;

  AST_OUTPUT_EXCLUDED: assert property (@(posedge clk) disable iff (!rstN)
    (watchDir == '0) |-> !anyMismatch);  // R2

  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.capture && $stable(watchLevel)) |=> (watchLevel == refSnap));  // R3

endmodule

// File: rtl/port_chg_ctrl.sv
module port_chg_ctrl
  import port_chg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    portRead,
  input  logic    portWrite,
  input  logic    flagClear,
  input  logic    intEnable,
  input  logic    anyMismatch,
  output chgCtl_t ctl,
  output logic    chgFlag,
  output logic    irqReq,
  output logic    wakeReq
);

  // Reference follows pins during reset and on every port access
  always_comb begin
    ctl.capture = !rstN | portRead | portWrite;
  end

  // Sticky flag: set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN)            chgFlag <= 1'b0;
    else if (anyMismatch) chgFlag <= 1'b1;
    else if (flagClear)   chgFlag <= 1'b0;
  end

  assign irqReq  = intEnable & chgFlag;
  assign wakeReq = intEnable & (chgFlag | anyMismatch);

  AST_FLAG_SET_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    anyMismatch |=> chgFlag);  // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (chgFlag && !flagClear) |=> chgFlag);  // R5

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (anyMismatch && flagClear) |=> chgFlag);  // R6

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (flagClear && !anyMismatch) |=> !chgFlag);  // R7

endmodule

// File: rtl/port_chg_detect.sv
module port_chg_detect
  import port_chg_pkg::*;
#(
  parameter int PORT_W = 8,
  parameter int CHG_LO = 4,
  localparam int CHG_W = PORT_W - CHG_LO
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PORT_W-1:0] pinLevel,
  input  logic [PORT_W-1:0] dirIn,
  input  logic [CHG_W-1:0]  chgEnable,
  input  logic              intEnable,
  input  logic              portRead,
  input  logic              portWrite,
  input  logic              flagClear,
  output logic              chgFlag,
  output logic              irqReq,
  output logic              wakeReq
);

  chgCtl_t ctl;
  logic    anyMismatch;

  port_chg_datapath #(.CHG_W(CHG_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .watchLevel (pinLevel[PORT_W-1:CHG_LO]),
    .watchDir   (dirIn[PORT_W-1:CHG_LO]),
    .watchEn    (chgEnable),
    .anyMismatch(anyMismatch)
  );

  port_chg_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .portRead   (portRead),
    .portWrite  (portWrite),
    .flagClear  (flagClear),
    .intEnable  (intEnable),
    .anyMismatch(anyMismatch),
    .ctl        (ctl),
    .chgFlag    (chgFlag),
    .irqReq     (irqReq),
    .wakeReq    (wakeReq)
  );

  AST_WAKE_COVERS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> wakeReq);  // R9

  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !intEnable |-> (!irqReq && !wakeReq));  // R8

endmodule

// File: tb/sim_port_chg_detect.sv
module sim_port_chg_detect;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] pinLevel = 8'h00;
  logic [7:0] dirIn = 8'hFF;
  logic [3:0] chgEnable = 4'hF;
  logic       intEnable = 1'b1;
  logic       portRead = 1'b0;
  logic       portWrite = 1'b0;
  logic       flagClear = 1'b0;
  logic       chgFlag, irqReq, wakeReq;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;  // 50 MHz

  port_chg_detect u0 (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .dirIn(dirIn),
    .chgEnable(chgEnable), .intEnable(intEnable), .portRead(portRead),
    .portWrite(portWrite), .flagClear(flagClear), .chgFlag(chgFlag),
    .irqReq(irqReq), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Read the port, then clear the flag: leaves a quiet state
  task automatic settle();
    portRead = 1'b1; cyc(); portRead = 1'b0;
    flagClear = 1'b1; cyc(); flagClear = 1'b0;
  endtask

  task automatic t_reset();
    pinLevel = 8'hB0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc(); cyc();
    check("R10", "flag after reset", chgFlag, 1'b0);
    check("R10", "irq after reset", irqReq, 1'b0);
    check("R10", "wake after reset", wakeReq, 1'b0);
  endtask

  task automatic t_set_and_wake();
    pinLevel = 8'h00; settle();
    check("R9", "wake quiet", wakeReq, 1'b0);
    pinLevel = 8'h20; #1;
    check("R9", "wake before edge", wakeReq, 1'b1);
    check("R4", "flag before edge", chgFlag, 1'b0);
    cyc();
    check("R4", "flag after edge", chgFlag, 1'b1);
    check("R8", "irq enabled", irqReq, 1'b1);
  endtask

  task automatic t_access_then_clear();
    portRead = 1'b1; cyc(); portRead = 1'b0;
    check("R5", "flag after read", chgFlag, 1'b1);
    cyc();
    check("R5", "flag holds", chgFlag, 1'b1);
    flagClear = 1'b1; cyc(); flagClear = 1'b0;
    check("R7", "flag cleared", chgFlag, 1'b0);
    cyc();
    check("R3", "no re-set after read", chgFlag, 1'b0);
  endtask

  task automatic t_write_capture();
    pinLevel = 8'h60; cyc();
    check("R4", "flag on pin6", chgFlag, 1'b1);
    portWrite = 1'b1; cyc(); portWrite = 1'b0;
    flagClear = 1'b1; cyc(); flagClear = 1'b0;
    cyc();
    check("R3", "write captured reference", chgFlag, 1'b0);
  endtask

  task automatic t_set_beats_clear();
    pinLevel = 8'hE0; cyc();
    check("R4", "flag on pin7", chgFlag, 1'b1);
    flagClear = 1'b1; cyc(); flagClear = 1'b0;
    check("R6", "clear lost to mismatch", chgFlag, 1'b1);
    settle();
  endtask

  task automatic t_low_pins();
    pinLevel = 8'hEF; cyc();
    pinLevel = 8'hE5; cyc();
    check("R1", "low pins ignored flag", chgFlag, 1'b0);
    check("R1", "low pins ignored wake", wakeReq, 1'b0);
  endtask

  task automatic t_disabled_pin();
    settle();
    chgEnable = 4'b1110;
    pinLevel = pinLevel ^ 8'h10; cyc(); cyc();
    check("R1", "disabled pin4 ignored", chgFlag, 1'b0);
    chgEnable = 4'hF; cyc();
    check("R1", "re-enabled pin4 vs access copy", chgFlag, 1'b1);
    settle();
  endtask

  task automatic t_output_pin();
    dirIn = 8'hBF;
    pinLevel = pinLevel ^ 8'h40; cyc(); cyc();
    check("R2", "output pin6 excluded", chgFlag, 1'b0);
    check("R2", "output pin6 no wake", wakeReq, 1'b0);
    dirIn = 8'hFF;
    settle();
  endtask

  task automatic t_gate();
    intEnable = 1'b0;
    pinLevel = pinLevel ^ 8'h80; #1;
    check("R9", "wake gated off", wakeReq, 1'b0);
    cyc();
    check("R8", "flag sets while gated", chgFlag, 1'b1);
    check("R8", "irq gated off", irqReq, 1'b0);
    intEnable = 1'b1; #1;
    check("R8", "irq when enabled", irqReq, 1'b1);
    check("R9", "wake from flag", wakeReq, 1'b1);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_set_and_wake();
    t_access_then_clear();
    t_write_capture();
    t_set_beats_clear();
    t_low_pins();
    t_disabled_pin();
    t_output_pin();
    t_gate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule